// File: doc/BRIEF.md
# Legacy PC Miscellaneous Port Controller

This block sits on a simple byte-oriented host I/O port bus and answers a handful of fixed legacy system ports. It keeps the fast address-line-20 gate as a register that software can write and read back. It latches an external floating-point error event into an interrupt level, and a write to a dedicated port clears that level. It also gives boot firmware a set of debug ports: two panic channels, each with its own code register, and a character output strobe.

A power-off detector watches one port for an eight-character password written one byte at a time, in order. When the last character arrives it issues a one-cycle shutdown request. Any wrong byte sends the detector back to its first character.

All outputs except the read data are registered. Read data is combinational from the address and the read strobe. Addresses that the block does not decode are ignored. The reset input is asynchronous and active-low. Inside the block it is released synchronously after two clock edges.

Top module: `pc_misc_ports`

## Requirements
- R1: After reset the A20 enable, the FPU error level, both panic codes, all pulse outputs and the password match position are zero. A match position of zero is shown by a full eight-byte password being needed to raise a shutdown request.
- R2: A write to port 0x0092 copies data bit 1 into `a20_en`, visible one cycle after the write. Data bit 0 has no effect on any output.
- R3: A read of port 0x0092 returns `a20_en` in bit 1 and zero in all other bits, in the same cycle as the read strobe.
- R4: A high `fpu_err_evt` sets `fpu_err_irq` one cycle later. A write to port 0x00F0 clears it one cycle later. If both happen in the same cycle, the set wins.
- R5: A write to port 0x0080 changes no output.
- R6: Port 0x8900 compares the low data byte with the next expected character of "Shutdown" (0x53 0x68 0x75 0x74 0x64 0x6F 0x77 0x6E). On the eighth consecutive match, `shutdown_req` goes high for exactly one cycle, one cycle after that write, and the match position returns to the first character.
- R7: A byte that does not match sends the match position back to the first character. That byte is not compared again against the first character, so an 'S' that breaks a partial match does not start a new attempt.
- R8: A write to port 0x0400 or 0x0401 latches the 16-bit data into `panic_code_sys` and raises `panic_pulse` with `panic_src` = 0 for one cycle. A write to port 0x0501 or 0x0502 does the same with `panic_code_vid` and `panic_src` = 1. Each code register keeps its value until the next panic write from its own source.
- R9: A write to port 0x0402, 0x0403, 0x0500 or 0x0503 raises `dbg_char_stb` for one cycle with `dbg_char` equal to the low data byte, one cycle after the write.
- R10: A read of any address other than 0x0092 returns 0x00. A write to an undecoded address changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Port address |
| io_wdata | input | 16 | Write data |
| io_wr | input | 1 | Write strobe, one access per high cycle |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| fpu_err_evt | input | 1 | FPU error event |
| a20_en | output | 1 | Address line 20 gate enable |
| fpu_err_irq | output | 1 | FPU error interrupt level |
| panic_pulse | output | 1 | One-cycle firmware panic indication |
| panic_src | output | 1 | Panic source: 0 system firmware, 1 video firmware |
| panic_code_sys | output | 16 | Last system firmware panic code |
| panic_code_vid | output | 16 | Last video firmware panic code |
| dbg_char_stb | output | 1 | Debug character strobe |
| dbg_char | output | 8 | Debug character byte |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it one nanosecond after driving the strobe. Every registered result appears on the edge that ends the write cycle. The bench drives each stimulus on a falling edge and samples on the next falling edge. The panic, character and shutdown events are pushed into a scoreboard queue as the driver issues the write that should cause them. A falling-edge monitor pops and compares each pulse, so a pulse that comes late, comes early or was never expected is reported. The password cases are broken-sequence traces, including a stray 'S', and they rely on that monitor to catch a request that fires too early.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  localparam logic [15:0] PORT_DELAY    = 16'h0080;
  localparam logic [15:0] PORT_A20      = 16'h0092;
  localparam logic [15:0] PORT_FPU_CLR  = 16'h00F0;
  localparam logic [15:0] PORT_SPANIC_A = 16'h0400;
  localparam logic [15:0] PORT_SPANIC_B = 16'h0401;
  localparam logic [15:0] PORT_SCHAR_A  = 16'h0402;
  localparam logic [15:0] PORT_SCHAR_B  = 16'h0403;
  localparam logic [15:0] PORT_VCHAR_A  = 16'h0500;
  localparam logic [15:0] PORT_VPANIC_A = 16'h0501;
  localparam logic [15:0] PORT_VPANIC_B = 16'h0502;
  localparam logic [15:0] PORT_VCHAR_B  = 16'h0503;
  localparam logic [15:0] PORT_POWEROFF = 16'h8900;

  typedef struct packed {
    logic a20_wr;
    logic a20_rd;
    logic fpu_clr;
    logic sys_panic;
    logic vid_panic;
    logic dbg_chr;
    logic pwr_wr;
    logic known_wr;
  } pcm_hit_t;

endpackage

// File: rtl/pcm_decode.sv
module pcm_decode
  import pcm_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic        rd,
  output pcm_hit_t    hit
);

  logic sel_sys_panic, sel_vid_panic, sel_chr;

  always_comb begin
    sel_sys_panic = (addr == PORT_SPANIC_A) || (addr == PORT_SPANIC_B);
    sel_vid_panic = (addr == PORT_VPANIC_A) || (addr == PORT_VPANIC_B);
    sel_chr       = (addr == PORT_SCHAR_A) || (addr == PORT_SCHAR_B) ||
                    (addr == PORT_VCHAR_A) || (addr == PORT_VCHAR_B);

    hit.a20_wr    = wr && (addr == PORT_A20);
    hit.a20_rd    = rd && (addr == PORT_A20);
    hit.fpu_clr   = wr && (addr == PORT_FPU_CLR);
    hit.sys_panic = wr && sel_sys_panic;
    hit.vid_panic = wr && sel_vid_panic;
    hit.dbg_chr   = wr && sel_chr;
    hit.pwr_wr    = wr && (addr == PORT_POWEROFF);
    hit.known_wr  = wr && (sel_sys_panic || sel_vid_panic || sel_chr ||
                           (addr == PORT_A20) || (addr == PORT_FPU_CLR) ||
                           (addr == PORT_DELAY) || (addr == PORT_POWEROFF));
  end

endmodule

// File: rtl/pcm_sysctl.sv
module pcm_sysctl (
  input  logic clk,
  input  logic rst_n,
  input  logic a20_wr,
  input  logic a20_bit,
  input  logic fpu_clr,
  input  logic fpu_evt,
  output logic a20_en,
  output logic fpu_irq
);

  logic a20_q, fpu_q, fpu_d, fpu_ce;

  always_comb begin
    fpu_ce = fpu_evt || fpu_clr;
    fpu_d  = fpu_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a20_q <= 1'b0;
      fpu_q <= 1'b0;
    end else begin
      if (a20_wr) a20_q <= a20_bit;
      if (fpu_ce) fpu_q <= fpu_d;
    end
  end

  assign a20_en  = a20_q;
  assign fpu_irq = fpu_q;

  assert_a20_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(a20_wr) |-> (a20_en == $past(a20_bit)));
  assert_a20_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(a20_wr) |-> $stable(a20_en));
  assert_fpu_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fpu_evt) |-> fpu_irq);
  assert_fpu_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fpu_clr && !fpu_evt) |-> !fpu_irq);

endmodule

// File: rtl/pcm_poweroff_seq.sv
module pcm_poweroff_seq #(
  parameter int CHAR_W  = 8,
  parameter int SEQ_LEN = 8,
  parameter logic [CHAR_W*SEQ_LEN-1:0] SEQ = "Shutdown"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wbyte,
  output logic              req
);

  localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CHAR_W-1:0] expect_chr;
  logic              match, last, req_q;

  function automatic logic [CHAR_W-1:0] char_at(input logic [IDX_W-1:0] i);
    return SEQ[CHAR_W*(SEQ_LEN-1-int'(i)) +: CHAR_W];
  endfunction

  always_comb begin
    expect_chr = char_at(idx_q);
    match      = (wbyte == expect_chr);
    last       = match && (idx_q == LAST_IDX);
    idx_d      = (match && !last) ? idx_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (wr) idx_q <= idx_d;
      req_q <= wr && last;
    end
  end

  assign req = req_q;

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  assert_req_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (idx_q == '0));
  assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(wr));

endmodule

// File: rtl/pcm_fwdbg.sv
module pcm_fwdbg #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_panic,
  input  logic              vid_panic,
  input  logic              dbg_chr,
  input  logic [DATA_W-1:0] wdata,
  output logic              panic_pulse,
  output logic              panic_src,
  output logic [DATA_W-1:0] code_sys,
  output logic [DATA_W-1:0] code_vid,
  output logic              chr_stb,
  output logic [CHAR_W-1:0] chr
);

  logic [DATA_W-1:0] sys_q, vid_q;
  logic [CHAR_W-1:0] chr_q;
  logic              pulse_q, src_q, stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q   <= '0;
      vid_q   <= '0;
      chr_q   <= '0;
      pulse_q <= 1'b0;
      src_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      pulse_q <= sys_panic || vid_panic;
      stb_q   <= dbg_chr;
      if (sys_panic) sys_q <= wdata;
      if (vid_panic) vid_q <= wdata;
      if (sys_panic || vid_panic) src_q <= vid_panic;
      if (dbg_chr) chr_q <= wdata[CHAR_W-1:0];
    end
  end

  assign panic_pulse = pulse_q;
  assign panic_src   = src_q;
  assign code_sys    = sys_q;
  assign code_vid    = vid_q;
  assign chr_stb     = stb_q;
  assign chr         = chr_q;

  assert_sys_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sys_panic) |-> $stable(code_sys));
  assert_vid_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vid_panic) |-> $stable(code_vid));
  assert_chr_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chr_stb |-> (chr == $past(wdata[CHAR_W-1:0])));

endmodule

// File: rtl/pc_misc_ports.sv
module pc_misc_ports
  import pcm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CHAR_W  = 8,
  parameter int RD_W    = 8,
  parameter int SEQ_LEN = 8,
  parameter logic [CHAR_W*SEQ_LEN-1:0] SEQ = "Shutdown"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [RD_W-1:0]   io_rdata,
  input  logic              fpu_err_evt,
  output logic              a20_en,
  output logic              fpu_err_irq,
  output logic              panic_pulse,
  output logic              panic_src,
  output logic [DATA_W-1:0] panic_code_sys,
  output logic [DATA_W-1:0] panic_code_vid,
  output logic              dbg_char_stb,
  output logic [CHAR_W-1:0] dbg_char,
  output logic              shutdown_req
);

  localparam int A20_BIT = 1;

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  pcm_hit_t   hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pcm_decode u_decode (
    .addr (io_addr),
    .wr   (io_wr),
    .rd   (io_rd),
    .hit  (hit)
  );

  pcm_sysctl u_sysctl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .a20_wr  (hit.a20_wr),
    .a20_bit (io_wdata[A20_BIT]),
    .fpu_clr (hit.fpu_clr),
    .fpu_evt (fpu_err_evt),
    .a20_en  (a20_en),
    .fpu_irq (fpu_err_irq)
  );

  pcm_poweroff_seq #(
    .CHAR_W  (CHAR_W),
    .SEQ_LEN (SEQ_LEN),
    .SEQ     (SEQ)
  ) u_poweroff (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr    (hit.pwr_wr),
    .wbyte (io_wdata[CHAR_W-1:0]),
    .req   (shutdown_req)
  );

  pcm_fwdbg #(
    .DATA_W (DATA_W),
    .CHAR_W (CHAR_W)
  ) u_fwdbg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sys_panic   (hit.sys_panic),
    .vid_panic   (hit.vid_panic),
    .dbg_chr     (hit.dbg_chr),
    .wdata       (io_wdata),
    .panic_pulse (panic_pulse),
    .panic_src   (panic_src),
    .code_sys    (panic_code_sys),
    .code_vid    (panic_code_vid),
    .chr_stb     (dbg_char_stb),
    .chr         (dbg_char)
  );

  always_comb begin
    io_rdata = '0;
    if (hit.a20_rd) io_rdata[A20_BIT] = a20_en;
  end

  assert_rd_a20_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_rd && io_addr == PORT_A20) |-> (io_rdata == RD_W'({a20_en, 1'b0})));
  assert_rd_other_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_addr != PORT_A20) |-> (io_rdata == '0));
  assert_undecoded_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(io_wr && !hit.known_wr) |->
      ($stable(a20_en) && !panic_pulse && !dbg_char_stb && !shutdown_req));
  assert_delay_port_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(io_wr && io_addr == PORT_DELAY) |->
      ($stable(a20_en) && !panic_pulse && !dbg_char_stb && !shutdown_req));
  assert_panic_src_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    panic_pulse |-> (panic_src == $past(hit.vid_panic)));

endmodule

// File: tb/pc_misc_ports_tb.sv
module pc_misc_ports_tb;

  typedef struct {
    int          kind;   // 0 panic, 1 char, 2 shutdown
    logic [15:0] val;
    logic        src;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [15:0] io_wdata;
  logic        io_wr, io_rd, fpu_err_evt;
  logic [7:0]  io_rdata;
  logic        a20_en, fpu_err_irq, panic_pulse, panic_src;
  logic [15:0] panic_code_sys, panic_code_vid;
  logic        dbg_char_stb, shutdown_req;
  logic [7:0]  dbg_char;

  int   n_tests = 0;
  int   n_fail  = 0;
  int   n_sd    = 0;
  bit   mon_on  = 1'b0;
  bit   done    = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  pc_misc_ports u_dut (
    .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wdata (io_wdata),
    .io_wr (io_wr), .io_rd (io_rd), .io_rdata (io_rdata),
    .fpu_err_evt (fpu_err_evt), .a20_en (a20_en), .fpu_err_irq (fpu_err_irq),
    .panic_pulse (panic_pulse), .panic_src (panic_src),
    .panic_code_sys (panic_code_sys), .panic_code_vid (panic_code_vid),
    .dbg_char_stb (dbg_char_stb), .dbg_char (dbg_char),
    .shutdown_req (shutdown_req)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic push(input int kind, input logic [15:0] val,
                      input logic src, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.src = src; e.req = req;
    sb.push_back(e);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic send_str(input string s, input bit fire, input string req);
    for (int i = 0; i < s.len(); i++) begin
      if (fire && i == s.len() - 1) push(2, 16'h0, 1'b0, req);
      io_write(16'h8900, {8'h00, s[i]});
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && (panic_pulse || dbg_char_stb || shutdown_req)) begin
      exp_t e;
      int   k;
      logic [15:0] v;
      k = panic_pulse ? 0 : (dbg_char_stb ? 1 : 2);
      v = panic_pulse ? (panic_src ? panic_code_vid : panic_code_sys)
                      : (dbg_char_stb ? {8'h00, dbg_char} : 16'h0);
      if (shutdown_req) n_sd++;
      if (sb.size() == 0) begin
        check(1'b0, "R10", "unexpected event kind", 32'(k), 32'hFFFF_FFFF);
      end else begin
        e = sb.pop_front();
        check(k == e.kind, e.req, "event kind", 32'(k), 32'(e.kind));
        check(v == e.val, e.req, "event value", {16'h0, v}, {16'h0, e.val});
        if (k == 0)
          check(panic_src == e.src, e.req, "panic source",
                32'(panic_src), 32'(e.src));
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
    fpu_err_evt = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    check(a20_en == 1'b0, "R1", "a20_en", 32'(a20_en), 0);
    check(fpu_err_irq == 1'b0, "R1", "fpu_err_irq", 32'(fpu_err_irq), 0);
    check(panic_code_sys == 16'h0 && panic_code_vid == 16'h0, "R1", "panic codes",
          {panic_code_sys, panic_code_vid}, 0);
    check(!panic_pulse && !dbg_char_stb && !shutdown_req, "R1", "pulses",
          {29'h0, panic_pulse, dbg_char_stb, shutdown_req}, 0);

    // R2 A20 gate, bit 0 ignored
    io_write(16'h0092, 16'h0002);
    check(a20_en == 1'b1, "R2", "a20 set", 32'(a20_en), 1);
    io_write(16'h0092, 16'h0001);
    check(a20_en == 1'b0, "R2", "a20 clr bit0 ignored", 32'(a20_en), 0);
    io_write(16'h0092, 16'h00FF);
    check(a20_en == 1'b1, "R2", "a20 set all bits", 32'(a20_en), 1);

    // R3 readback
    io_read(16'h0092, rd);
    check(rd == 8'h02, "R3", "a20 read", 32'(rd), 32'h02);

    // R5 delay port
    io_write(16'h0080, 16'hFFFF);
    check(a20_en == 1'b1 && fpu_err_irq == 1'b0, "R5", "delay port outputs",
          {30'h0, a20_en, fpu_err_irq}, 32'h2);

    // R10 other reads and undecoded writes
    io_read(16'h0080, rd);
    check(rd == 8'h00, "R10", "read other port", 32'(rd), 0);
    io_write(16'h0093, 16'h0000);
    io_write(16'h0404, 16'h1111);
    io_write(16'h8901, 16'h0053);
    check(a20_en == 1'b1, "R10", "undecoded write a20", 32'(a20_en), 1);

    // R4 FPU error latch
    @(negedge clk); fpu_err_evt = 1'b1;
    @(negedge clk); fpu_err_evt = 1'b0;
    check(fpu_err_irq == 1'b1, "R4", "fpu set", 32'(fpu_err_irq), 1);
    repeat (2) @(negedge clk);
    check(fpu_err_irq == 1'b1, "R4", "fpu hold", 32'(fpu_err_irq), 1);
    io_write(16'h00F0, 16'h0000);
    check(fpu_err_irq == 1'b0, "R4", "fpu clear", 32'(fpu_err_irq), 0);
    @(negedge clk);
    io_addr = 16'h00F0; io_wr = 1'b1; fpu_err_evt = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; fpu_err_evt = 1'b0;
    check(fpu_err_irq == 1'b1, "R4", "fpu set beats clear", 32'(fpu_err_irq), 1);
    io_write(16'h00F0, 16'h0000);
    check(fpu_err_irq == 1'b0, "R4", "fpu clear again", 32'(fpu_err_irq), 0);

    // R8 panic channels
    push(0, 16'h1234, 1'b0, "R8"); io_write(16'h0400, 16'h1234);
    push(0, 16'hBEEF, 1'b0, "R8"); io_write(16'h0401, 16'hBEEF);
    push(0, 16'h0BAD, 1'b1, "R8"); io_write(16'h0501, 16'h0BAD);
    push(0, 16'h7777, 1'b1, "R8"); io_write(16'h0502, 16'h7777);
    @(negedge clk);
    check(panic_code_sys == 16'hBEEF, "R8", "sys code kept",
          32'(panic_code_sys), 32'hBEEF);
    check(panic_code_vid == 16'h7777, "R8", "vid code kept",
          32'(panic_code_vid), 32'h7777);

    // R9 debug characters
    push(1, 16'h0041, 1'b0, "R9"); io_write(16'h0402, 16'hAA41);
    push(1, 16'h0062, 1'b0, "R9"); io_write(16'h0403, 16'h0062);
    push(1, 16'h0063, 1'b0, "R9"); io_write(16'h0500, 16'h5563);
    push(1, 16'h0064, 1'b0, "R9"); io_write(16'h0503, 16'h0064);

    // R1 / R6 full password after reset
    send_str("Shutdown", 1'b1, "R6");
    @(negedge clk);
    check(n_sd == 1, "R6", "shutdown count", 32'(n_sd), 1);

    // R7 broken sequences, stray 'S' does not restart
    send_str("Shu", 1'b0, "R7");
    send_str("S", 1'b0, "R7");
    send_str("hutdown", 1'b0, "R7");
    send_str("Shutdow", 1'b0, "R7");
    send_str("x", 1'b0, "R7");
    @(negedge clk);
    check(n_sd == 1, "R7", "no shutdown on broken", 32'(n_sd), 1);
    send_str("Shutdown", 1'b1, "R7");
    @(negedge clk);
    check(n_sd == 2, "R7", "shutdown after restart", 32'(n_sd), 2);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R6", "scoreboard drained", 32'(sb.size()), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule